// File: doc/BRIEF.md
# Store-and-Forward Packet Transmit Buffer

This block sits in front of a transmit AXI4-Stream port whose receiver does not allow a gap inside a packet. Once that port has seen the first beat of a packet, tvalid must stay high on every cycle until the beat with tlast has been taken. The application side may deliver beats with pauses anywhere in a packet. The buffer therefore writes every beat into an internal RAM. Each entry holds the data, one keep bit per 32-bit DW, the user bits and the last flag. A packet becomes visible downstream only after its tlast beat has been written.

A counter of complete packets is raised on each stored tlast and lowered on each sent tlast. The output tvalid is high exactly when this counter is nonzero. A packet that has been released is already fully present, so it leaves without a bubble. If another complete packet is waiting, it follows directly after the previous tlast.

Descriptor beats pass through unchanged, whether a 4-DW request descriptor or a 3-DW completion descriptor, and so does any payload. The depth must be a power of two, at least 2. A packet longer than the depth fills the RAM without completing. That case is latched on a sticky error flag until reset.

Top module: `pkt_tx_buffer`

## Requirements
- R1: m_tvalid is low until a tlast beat has been accepted on the input. It goes high on the first cycle after the clock edge that accepts that tlast.
- R2: Once a beat is presented, m_tvalid stays high on every cycle until the beat carrying m_tlast has been accepted.
- R3: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tkeep, m_tuser and m_tlast keep their values on the next cycle.
- R4: Every beat leaves with the same data, keep (bit i covers DW i, bits [32i+31:32i]), user and last values it was written with. This holds for 3-DW and 4-DW descriptor beats alike.
- R5: Packets leave in arrival order. With m_tready held high and the next packet already complete, the next packet's first beat is sent on the cycle right after the previous tlast, with no idle cycle.
- R6: s_tready and buf_full reflect the stored beat count: s_tready is low and buf_full is high exactly when DEPTH beats are stored. While s_tready is low, input beats are not taken.
- R7: After reset, no beats are stored. buf_empty is high whenever no beat is stored.
- R8: oversize_err rises on the cycle after the RAM holds DEPTH beats with no complete packet among them. It stays high until reset.
- R9: Input pauses at any point inside a packet do not alter the stored beats or the order in which they leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat can be taken (RAM not full) |
| s_tdata | input | DATA_W | Input beat data |
| s_tkeep | input | DATA_W/32 | Input keep, one bit per DW |
| s_tuser | input | USER_W | Input side-band bits, stored with the beat |
| s_tlast | input | 1 | Input beat ends a packet |
| m_tvalid | output | 1 | Output beat valid, high while a complete packet is stored |
| m_tready | input | 1 | Downstream takes the beat |
| m_tdata | output | DATA_W | Output beat data |
| m_tkeep | output | DATA_W/32 | Output keep, one bit per DW |
| m_tuser | output | USER_W | Output side-band bits |
| m_tlast | output | 1 | Output beat ends a packet |
| buf_full | output | 1 | DEPTH beats stored |
| buf_empty | output | 1 | No beat stored |
| oversize_err | output | 1 | Sticky: a packet larger than the RAM was seen |

## Verification
All state changes on the accepting clock edge. The output side reads the RAM combinationally at the read pointer, so a handshake at an edge shows its effect on s_tready, m_tvalid, the head beat and the flags in the very next cycle. oversize_err is the one exception: it appears one cycle after the full-without-packet condition is first seen. The bench keeps a queue model that it updates at each rising edge, from the inputs it drives and the outputs the model predicts. It compares the design's outputs with the model at the following falling edge, half a period after the results are due. Separate checks at the same sampling point cover the latency of the first beat after tlast, the gap-free span of back-to-back packets, and the hold-under-stall behaviour, by comparing with the previous cycle's values.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
    // Width of one keep lane: each keep bit covers one 32-bit DW.
    localparam int unsigned DW_BITS = 32;
endpackage

// File: rtl/pkt_tx_updown.sv
module pkt_tx_updown #(
    parameter int unsigned MAX = 16,
    localparam int unsigned CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        case ({inc, dec})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pkt_tx_store.sv
module pkt_tx_store #(
    parameter int unsigned WIDTH = 273,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Combinational read so the head beat is visible with no extra cycle.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pkt_tx_buffer.sv
module pkt_tx_buffer
    import pkt_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned USER_W = 8,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s_tvalid,
    output logic                     s_tready,
    input  logic [DATA_W-1:0]        s_tdata,
    input  logic [DATA_W/DW_BITS-1:0] s_tkeep,
    input  logic [USER_W-1:0]        s_tuser,
    input  logic                     s_tlast,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic [DATA_W-1:0]        m_tdata,
    output logic [DATA_W/DW_BITS-1:0] m_tkeep,
    output logic [USER_W-1:0]        m_tuser,
    output logic                     m_tlast,
    output logic                     buf_full,
    output logic                     buf_empty,
    output logic                     oversize_err
);
    localparam int unsigned KEEP_W  = DATA_W / DW_BITS;
    localparam int unsigned AW      = $clog2(DEPTH);
    localparam int unsigned CW      = $clog2(DEPTH + 1);
    localparam int unsigned ENTRY_W = DATA_W + KEEP_W + USER_W + 1;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic          oversize;
    } buf_state_t;

    buf_state_t st_d, st_q;

    logic [CW-1:0]      occ_cnt, pkt_cnt;
    logic               occ_full, pkt_none;
    logic               wr_fire, rd_fire;
    logic [ENTRY_W-1:0] wr_entry, rd_entry;

    assign occ_full = (occ_cnt == CW'(DEPTH));
    assign pkt_none = (pkt_cnt == '0);

    assign s_tready = !occ_full;
    assign m_tvalid = !pkt_none;
    assign wr_fire  = s_tvalid && !occ_full;
    assign rd_fire  = m_tvalid && m_tready;

    assign wr_entry = {s_tlast, s_tuser, s_tkeep, s_tdata};
    assign {m_tlast, m_tuser, m_tkeep, m_tdata} = rd_entry;

    always_comb begin
        st_d = st_q;
        if (wr_fire) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
        if (rd_fire) st_d.rd_ptr = st_q.rd_ptr + AW'(1);
        // RAM full with no finished packet: nothing can ever drain.
        st_d.oversize = st_q.oversize | (occ_full & pkt_none);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pkt_tx_store #(
        .WIDTH (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (st_q.wr_ptr),
        .wdata (wr_entry),
        .raddr (st_q.rd_ptr),
        .rdata (rd_entry)
    );

    // Stored beat count.
    pkt_tx_updown #(.MAX(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_fire),
        .dec   (rd_fire),
        .cnt   (occ_cnt)
    );

    // Complete packets held: raised by a stored tlast, lowered by a sent one.
    pkt_tx_updown #(.MAX(DEPTH)) u_pkts (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_fire && s_tlast),
        .dec   (rd_fire && m_tlast),
        .cnt   (pkt_cnt)
    );

    assign buf_full     = occ_full;
    assign buf_empty    = (occ_cnt == '0);
    assign oversize_err = st_q.oversize;
endmodule

// File: rtl/pkt_tx_buffer_chk.sv
module pkt_tx_buffer_chk
    import pkt_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned USER_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      s_tvalid,
    input logic                      s_tready,
    input logic                      s_tlast,
    input logic                      m_tvalid,
    input logic                      m_tready,
    input logic [DATA_W-1:0]         m_tdata,
    input logic [DATA_W/DW_BITS-1:0] m_tkeep,
    input logic [USER_W-1:0]         m_tuser,
    input logic                      m_tlast,
    input logic                      buf_full,
    input logic                      buf_empty,
    input logic                      oversize_err
);
    // Independent count of tlast beats in minus tlast beats out.
    logic [15:0] done_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= '0;
        else done_q <= done_q
                     + 16'(s_tvalid && s_tready && s_tlast)
                     - 16'(m_tvalid && m_tready && m_tlast);
    end

    // R1
    release_after_tlast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (done_q != 16'd0));

    // R2
    no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !m_tlast) |=> m_tvalid);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                     && $stable(m_tuser) && $stable(m_tlast)));

    // R6
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !s_tready);

    // R7
    empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !m_tvalid);

    // R8
    oversize_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !m_tvalid) |=> oversize_err);

    // R8
    oversize_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_err |=> oversize_err);
endmodule

bind pkt_tx_buffer pkt_tx_buffer_chk #(.DATA_W(DATA_W), .USER_W(USER_W)) u_chk (.*);

// File: tb/pkt_tx_buffer_bench.sv
module pkt_tx_buffer_bench;
    localparam int DATA_W = 256;
    localparam int USER_W = 8;
    localparam int KEEP_W = DATA_W / 32;
    localparam int DEPTH  = 16;

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic [KEEP_W-1:0] k;
        logic [USER_W-1:0] u;
        logic              l;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, m_tready = 1'b0;
    logic [DATA_W-1:0] s_tdata = '0;
    logic [KEEP_W-1:0] s_tkeep = '0;
    logic [USER_W-1:0] s_tuser = '0;
    logic s_tready, m_tvalid, m_tlast, buf_full, buf_empty, oversize_err;
    logic [DATA_W-1:0] m_tdata;
    logic [KEEP_W-1:0] m_tkeep;
    logic [USER_W-1:0] m_tuser;

    always #2 clk = ~clk;

    pkt_tx_buffer #(.DATA_W(DATA_W), .USER_W(USER_W), .DEPTH(DEPTH)) u_pkt_tx_buffer (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .buf_full(buf_full), .buf_empty(buf_empty), .oversize_err(oversize_err)
    );

    int checks = 0;
    int errors = 0;
    beat_t tx_q[$];
    beat_t mdl_q[$];
    int pkt_done = 0;
    bit exp_ovf = 1'b0;
    bit gap_en = 1'b0;
    int rdy_mode = 1;
    string data_tag = "R4";
    bit meas_en = 1'b0;
    int mcyc = 0, first_rd = -1, last_rd = -1, rd_n = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reference model, advanced on each rising edge from pre-edge values.
    always @(posedge clk) begin
        bit wr, rd, nov;
        if (!rst_n) begin
            mdl_q.delete();
            pkt_done = 0;
            exp_ovf = 1'b0;
        end else begin
            mcyc++;
            wr  = s_tvalid && (mdl_q.size() < DEPTH);
            rd  = (pkt_done > 0) && m_tready;
            nov = exp_ovf || (mdl_q.size() == DEPTH && pkt_done == 0);
            if (rd) begin
                if (mdl_q[0].l) pkt_done--;
                void'(mdl_q.pop_front());
                if (meas_en) begin
                    if (first_rd < 0) first_rd = mcyc;
                    last_rd = mcyc;
                    rd_n++;
                end
            end
            if (wr) begin
                mdl_q.push_back('{d: s_tdata, k: s_tkeep, u: s_tuser, l: s_tlast});
                if (s_tlast) pkt_done++;
                void'(tx_q.pop_front());
            end
            exp_ovf = nov;
        end
    end

    // Per-cycle compare and stimulus drive at the falling edge.
    initial begin
        bit pv, pr, pl;
        logic [DATA_W-1:0] pd;
        pv = 0; pr = 0; pl = 0; pd = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(s_tready == (mdl_q.size() < DEPTH), "R6 s_tready", DATA_W'(s_tready), DATA_W'(mdl_q.size() < DEPTH));
                chk(buf_full == (mdl_q.size() == DEPTH), "R6 buf_full", DATA_W'(buf_full), DATA_W'(mdl_q.size() == DEPTH));
                chk(buf_empty == (mdl_q.size() == 0), "R7 buf_empty", DATA_W'(buf_empty), DATA_W'(mdl_q.size() == 0));
                chk(oversize_err == exp_ovf, "R8 oversize_err", DATA_W'(oversize_err), DATA_W'(exp_ovf));
                chk(m_tvalid == (pkt_done > 0), "R1 m_tvalid", DATA_W'(m_tvalid), DATA_W'(pkt_done > 0));
                if (pkt_done > 0) begin
                    chk(m_tdata == mdl_q[0].d, {data_tag, " m_tdata"}, m_tdata, mdl_q[0].d);
                    chk(m_tkeep == mdl_q[0].k, {data_tag, " m_tkeep"}, DATA_W'(m_tkeep), DATA_W'(mdl_q[0].k));
                    chk(m_tuser == mdl_q[0].u, {data_tag, " m_tuser"}, DATA_W'(m_tuser), DATA_W'(mdl_q[0].u));
                    chk(m_tlast == mdl_q[0].l, {data_tag, " m_tlast"}, DATA_W'(m_tlast), DATA_W'(mdl_q[0].l));
                end
                if (pv && pr && !pl)
                    chk(m_tvalid == 1'b1, "R2 mid-packet valid", DATA_W'(m_tvalid), DATA_W'(1));
                if (pv && !pr) begin
                    chk(m_tvalid == 1'b1, "R3 valid held", DATA_W'(m_tvalid), DATA_W'(1));
                    chk(m_tdata == pd, "R3 data held", m_tdata, pd);
                end
            end
            if (tx_q.size() > 0) begin
                s_tvalid = !gap_en || ($urandom % 3 != 0);
                s_tdata  = tx_q[0].d;
                s_tkeep  = tx_q[0].k;
                s_tuser  = tx_q[0].u;
                s_tlast  = tx_q[0].l;
            end else begin
                s_tvalid = 1'b0;
                s_tdata  = '0;
                s_tkeep  = '0;
                s_tuser  = '0;
                s_tlast  = 1'b0;
            end
            m_tready = (rdy_mode == 1) || (rdy_mode == 2 && ($urandom % 2 == 0));
            pv = rst_n && m_tvalid;
            pr = m_tready;
            pl = m_tlast;
            pd = m_tdata;
        end
    end

    int wd_cyc = 0;
    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd_cyc, 100000);
            summary();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic add_pkt(input int nb, input int tail_dw, input int desc_dw);
        for (int i = 0; i < nb; i++) begin
            beat_t b;
            b.d = {$urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom};
            b.k = (i == nb - 1) ? KEEP_W'((1 << tail_dw) - 1) : '1;
            b.u = {4'(i), 4'(desc_dw)};
            b.l = (i == nb - 1);
            tx_q.push_back(b);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (tx_q.size() == 0 && mdl_q.size() == 0) break;
            step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_q.delete();
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        // R7 reset state
        chk(buf_empty == 1'b1, "R7 reset empty", DATA_W'(buf_empty), DATA_W'(1));
        chk(buf_full == 1'b0, "R7 reset full", DATA_W'(buf_full), DATA_W'(0));
        chk(m_tvalid == 1'b0, "R7 reset m_tvalid", DATA_W'(m_tvalid), DATA_W'(0));
        chk(s_tready == 1'b1, "R7 reset s_tready", DATA_W'(s_tready), DATA_W'(1));
        chk(oversize_err == 1'b0, "R7 reset oversize_err", DATA_W'(oversize_err), DATA_W'(0));

        // R1: nothing leaves before tlast is taken, then the head shows next cycle
        rdy_mode = 1;
        add_pkt(3, 5, 4);
        while (tx_q.size() > 0) begin
            chk(m_tvalid == 1'b0, "R1 held before tlast", DATA_W'(m_tvalid), DATA_W'(0));
            step();
        end
        chk(m_tvalid == 1'b1, "R1 released after tlast", DATA_W'(m_tvalid), DATA_W'(1));
        drain();

        // R9 / R4: input pauses, random stalls, 4-DW and 3-DW descriptor packets
        data_tag = "R9";
        gap_en = 1'b1;
        rdy_mode = 2;
        add_pkt(1, 4, 4);
        add_pkt(1, 3, 3);
        add_pkt(4, 7, 4);
        add_pkt(2, 3, 3);
        add_pkt(5, 8, 4);
        drain();
        data_tag = "R4";
        gap_en = 1'b0;

        // R5: back-to-back packets, no idle cycle between them, in order
        rdy_mode = 1;
        meas_en = 1'b1;
        for (int p = 0; p < 4; p++) add_pkt(3, 2 + p, 4);
        drain();
        meas_en = 1'b0;
        chk(rd_n == 12, "R5 beats out", DATA_W'(rd_n), DATA_W'(12));
        chk(last_rd - first_rd + 1 == 12, "R5 gap-free span",
            DATA_W'(last_rd - first_rd + 1), DATA_W'(12));

        // R6: full buffer withholds s_tready
        rdy_mode = 0;
        for (int p = 0; p < 6; p++) add_pkt(3, 8, 3);
        repeat (30) step();
        chk(s_tready == 1'b0, "R6 full stops input", DATA_W'(s_tready), DATA_W'(0));
        chk(buf_full == 1'b1, "R6 full flag", DATA_W'(buf_full), DATA_W'(1));
        chk(tx_q.size() == 2, "R6 beats left upstream", DATA_W'(tx_q.size()), DATA_W'(2));
        rdy_mode = 2;
        drain();

        // R8: packet longer than the RAM
        rdy_mode = 1;
        add_pkt(DEPTH + 4, 8, 4);
        repeat (30) step();
        chk(oversize_err == 1'b1, "R8 oversize set", DATA_W'(oversize_err), DATA_W'(1));
        chk(m_tvalid == 1'b0, "R8 nothing released", DATA_W'(m_tvalid), DATA_W'(0));
        repeat (5) step();
        chk(oversize_err == 1'b1, "R8 oversize sticky", DATA_W'(oversize_err), DATA_W'(1));
        do_reset();
        chk(oversize_err == 1'b0, "R8 cleared by reset", DATA_W'(oversize_err), DATA_W'(0));
        chk(buf_empty == 1'b1, "R7 empty after reset", DATA_W'(buf_empty), DATA_W'(1));

        repeat (3) step();
        summary();
    end
endmodule